// File: doc/BRIEF.md
# Timestamped Sample Cluster Expander

This block turns a stream of captured-memory bytes into a stream of 4-bit logic samples. The bytes arrive in 16-byte clusters. Each cluster holds one 16-bit timestamp followed by seven 16-bit event words, all little-endian. Every event word packs four consecutive samples of four channels in interleaved form, so one cluster yields 28 samples. One timestamp unit covers 20 ns, which is four samples of a 200 MHz capture.

When the timestamp advances by more than the seven units a cluster spans, the capture was idle in between. The expander fills that gap by repeating the last emitted sample before it emits the new cluster's samples. A block-start flag travels with the first byte of a readout block. It realigns cluster framing, and it makes that cluster's gap zero and the held sample zero.

The output is a valid/ready stream. The consumer may stall it at any point, during gap filling or during unpacking, and no sample is lost or repeated.

Top module: `ts_cluster_expander`

## Requirements
- R1: After reset, `smp_valid` is 0 and `byte_ready` is 1.
- R2: Bytes of a cluster are taken in order: timestamp low byte, then timestamp high byte, then for each of the seven event words its low byte followed by its high byte.
- R3: Each event word produces four samples in order k = 0, 1, 2, 3. Bit c of sample k (c = 0..3) equals bit k + 4*c of the event word. Event words are emitted in arrival order.
- R4: Before a cluster's 28 samples, the last emitted sample is repeated D*4 − 28 times, where D is the cluster timestamp minus the previous cluster's timestamp. No repeat is emitted when D ≤ 7.
- R5: A byte presented with `byte_blk_start` = 1 is taken as byte 0 of a new cluster and drops any partial cluster. For that cluster D counts as 1, so no gap fill is emitted, and the held sample is reset to 0.
- R6: D is computed modulo 2^16, so a timestamp that wraps past 0xFFFF still gives the correct gap. D = 0 emits no gap fill.
- R7: The held sample is the final sample (sample 3 of event 6) of the most recent cluster. The held sample and the previous timestamp carry across any number of clusters until the next block start.
- R8: While `smp_valid` = 1 and `smp_ready` = 0, `smp_valid` stays 1 and `smp_data` stays unchanged on the next cycle.
- R9: Samples are emitted exactly once each, gap fill first, and nothing is emitted that R3 to R5 do not call for.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Input byte present |
| byte_blk_start | input | 1 | Byte is the first of a readout block |
| byte_data | input | 8 | Input byte |
| byte_ready | output | 1 | Block can accept a byte this cycle |
| smp_valid | output | 1 | Output sample present |
| smp_ready | input | 1 | Consumer takes the sample this cycle |
| smp_data | output | 4 | Sample, bit c is channel c |

## Verification
The hardest situations to reach from the ports are a long gap fill that is cut up by consumer stalls, and a timestamp that wraps between two clusters. Random cluster gaps include some of several hundred samples, and the consumer's ready is random, with a phase where it is mostly low. Directed clusters force the wrap near 0xFFF8 and the zero-gap case. A block-start flag is sent after a partial cluster to show that the stale bytes are dropped. A block longer than 64 clusters checks that the held sample and the timestamp carry across chunk boundaries.

// File: rtl/tsx_pkg.sv
package tsx_pkg;
  localparam int CH   = 4;   // channels per sample
  localparam int SPE  = 4;   // samples per event word
  localparam int TS_W = 16;  // timestamp width
  localparam int EV_W = CH * SPE;

  typedef enum logic [1:0] {ST_IDLE, ST_PAD, ST_EMIT} exp_state_t;

  // channel c of sample k lives at bit k + SPE*c of the event word
  function automatic logic [CH-1:0] pick_sample(input logic [EV_W-1:0] ev,
                                                input logic [1:0] k);
    logic [CH-1:0] s;
    for (int c = 0; c < CH; c++) s[c] = ev[SPE*c + int'(k)];
    return s;
  endfunction
endpackage

// File: rtl/tsx_byte_gather.sv
module tsx_byte_gather
  import tsx_pkg::*;
#(
  parameter int N_EVENTS = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     in_first,
  input  logic [7:0]               in_data,
  output logic                     in_ready,
  input  logic                     take,
  output logic                     cl_valid,
  output logic                     cl_first,
  output logic [TS_W-1:0]          cl_ts,
  output logic [N_EVENTS*EV_W-1:0] cl_ev
);
  localparam int NB = 2 * (N_EVENTS + 1);
  localparam int CW = $clog2(NB);

  logic [7:0]    mem [NB];
  logic [CW-1:0] cnt_q, idx;
  logic          full_q, first_q, accept;

  assign in_ready = !full_q;
  assign accept   = in_valid && !full_q;
  assign idx      = in_first ? '0 : cnt_q;

  // byte storage without reset so it maps to distributed or block RAM
  always_ff @(posedge clk) begin
    if (accept) mem[idx] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      full_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      if (take) full_q <= 1'b0;
      if (accept) begin
        if (idx == '0) first_q <= in_first;
        if (idx == CW'(NB - 1)) begin
          full_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= idx + 1'b1;
        end
      end
    end
  end

  assign cl_valid = full_q;
  assign cl_first = first_q;
  assign cl_ts    = {mem[1], mem[0]};

  for (genvar g = 0; g < N_EVENTS; g++) begin : g_ev
    assign cl_ev[g*EV_W +: EV_W] = {mem[2*g+3], mem[2*g+2]};
  end
endmodule

// File: rtl/tsx_expand.sv
module tsx_expand
  import tsx_pkg::*;
#(
  parameter int N_EVENTS = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cl_valid,
  input  logic                     cl_first,
  input  logic [TS_W-1:0]          cl_ts,
  input  logic [N_EVENTS*EV_W-1:0] cl_ev,
  output logic                     take,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [CH-1:0]            out_sample
);
  localparam int PW      = TS_W + 2;            // gap-fill counter width
  localparam int PER_CL  = N_EVENTS * SPE;      // samples per cluster
  localparam int EI_W    = $clog2(N_EVENTS + 1);

  exp_state_t              st_q;
  logic [TS_W-1:0]         prev_ts_q, base, diff;
  logic [PW-1:0]           pad_q, pad_calc;
  logic [N_EVENTS*EV_W-1:0] ev_q;
  logic [EI_W-1:0]         ei_q;
  logic [1:0]              k_q;
  logic [CH-1:0]           last_q, cur;
  logic                    adv;

  assign base     = cl_first ? cl_ts - 1'b1 : prev_ts_q;
  assign diff     = cl_ts - base;
  assign pad_calc = (diff > TS_W'(N_EVENTS)) ? ({2'b00, diff} << 2) - PW'(PER_CL) : '0;
  assign take     = (st_q == ST_IDLE) && cl_valid;
  assign adv      = !out_valid || out_ready;
  assign cur      = pick_sample(ev_q[int'(ei_q)*EV_W +: EV_W], k_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      out_valid  <= 1'b0;
      out_sample <= '0;
      last_q     <= '0;
      prev_ts_q  <= '0;
      pad_q      <= '0;
      ei_q       <= '0;
      k_q        <= '0;
      ev_q       <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (adv) out_valid <= 1'b0;
          if (take) begin
            ev_q      <= cl_ev;
            prev_ts_q <= cl_ts;
            pad_q     <= pad_calc;
            ei_q      <= '0;
            k_q       <= '0;
            if (cl_first) last_q <= '0;
            st_q <= (pad_calc != '0) ? ST_PAD : ST_EMIT;
          end
        end
        ST_PAD: begin
          if (adv) begin
            out_valid  <= 1'b1;
            out_sample <= last_q;
            pad_q      <= pad_q - 1'b1;
            if (pad_q == PW'(1)) st_q <= ST_EMIT;
          end
        end
        default: begin
          if (adv) begin
            out_valid  <= 1'b1;
            out_sample <= cur;
            k_q        <= k_q + 1'b1;
            if (k_q == 2'd3) begin
              if (ei_q == EI_W'(N_EVENTS - 1)) begin
                last_q <= cur;
                st_q   <= ST_IDLE;
              end else begin
                ei_q <= ei_q + 1'b1;
              end
            end
          end
        end
      endcase
    end
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);  // R1

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));  // R8

  AST_FILL_IS_HELD: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_PAD) && $past(st_q == ST_PAD) && out_valid) |-> (out_sample == last_q));  // R4

  AST_BLOCK_START_NO_FILL: assert property (@(posedge clk) disable iff (rst)
    (take && cl_first) |=> (st_q != ST_PAD));  // R5
endmodule

// File: rtl/ts_cluster_expander.sv
module ts_cluster_expander
  import tsx_pkg::*;
#(
  parameter int N_EVENTS = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_valid,
  input  logic       byte_blk_start,
  input  logic [7:0] byte_data,
  output logic       byte_ready,
  output logic       smp_valid,
  input  logic       smp_ready,
  output logic [3:0] smp_data
);
  logic                     take, cl_valid, cl_first;
  logic [TS_W-1:0]          cl_ts;
  logic [N_EVENTS*EV_W-1:0] cl_ev;

  tsx_byte_gather #(.N_EVENTS(N_EVENTS)) u_gather (
    .clk      (clk),
    .rst      (rst),
    .in_valid (byte_valid),
    .in_first (byte_blk_start),
    .in_data  (byte_data),
    .in_ready (byte_ready),
    .take     (take),
    .cl_valid (cl_valid),
    .cl_first (cl_first),
    .cl_ts    (cl_ts),
    .cl_ev    (cl_ev)
  );

  tsx_expand #(.N_EVENTS(N_EVENTS)) u_expand (
    .clk        (clk),
    .rst        (rst),
    .cl_valid   (cl_valid),
    .cl_first   (cl_first),
    .cl_ts      (cl_ts),
    .cl_ev      (cl_ev),
    .take       (take),
    .out_valid  (smp_valid),
    .out_ready  (smp_ready),
    .out_sample (smp_data)
  );
endmodule

// File: tb/ts_cluster_expander_tb.sv
module ts_cluster_expander_tb;
  localparam int NEV = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;  // 50 MHz

  logic       byte_valid = 1'b0, byte_blk_start = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       byte_ready, smp_valid;
  logic       smp_ready = 1'b0;
  logic [3:0] smp_data;

  ts_cluster_expander #(.N_EVENTS(NEV)) u_dut (
    .clk(clk), .rst(rst),
    .byte_valid(byte_valid), .byte_blk_start(byte_blk_start),
    .byte_data(byte_data), .byte_ready(byte_ready),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data)
  );

  int checks = 0, errors = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic [15:0] m_prev = 16'h0;
  logic [3:0]  m_last = 4'h0;
  logic        prev_stall = 1'b0;
  logic [3:0]  prev_smp = 4'h0;
  bit          heavy = 1'b0;

  function automatic logic [3:0] model_sample(input logic [15:0] ev, input int k);
    logic [3:0] s;
    for (int c = 0; c < 4; c++) s[c] = ev[k + 4*c];
    return s;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit first);
    logic ok;
    byte_data = b; byte_blk_start = first; byte_valid = 1'b1;
    do begin
      ok = byte_ready;
      @(negedge clk);
    end while (!ok);
    byte_valid = 1'b0; byte_blk_start = 1'b0;
    if ($urandom % 5 == 0) @(negedge clk);
  endtask

  task automatic send_cluster(input logic [15:0] ts, input logic [16*NEV-1:0] ev,
                              input bit first, input string pad_tag, input string dat_tag);
    logic [15:0] d;
    int pad;
    d   = first ? 16'd1 : ts - m_prev;
    pad = (d > 16'd7) ? int'(d) * 4 - 4 * NEV : 0;
    if (first) m_last = 4'h0;
    repeat (pad) begin exp_q.push_back(m_last); tag_q.push_back(pad_tag); end
    for (int e = 0; e < NEV; e++)
      for (int k = 0; k < 4; k++) begin
        m_last = model_sample(ev[e*16 +: 16], k);
        exp_q.push_back(m_last); tag_q.push_back(dat_tag);
      end
    m_prev = ts;
    send_byte(ts[7:0], first);
    send_byte(ts[15:8], 1'b0);
    for (int e = 0; e < NEV; e++) begin
      send_byte(ev[e*16 +: 8], 1'b0);
      send_byte(ev[e*16+8 +: 8], 1'b0);
    end
  endtask

  function automatic logic [16*NEV-1:0] rand_events();
    logic [16*NEV-1:0] v;
    for (int e = 0; e < NEV; e++) v[e*16 +: 16] = 16'($urandom);
    return v;
  endfunction

  function automatic logic [15:0] rand_gap();
    int r;
    r = $urandom % 10;
    if (r < 6) return 16'($urandom % 9);
    else if (r < 9) return 16'(8 + $urandom % 20);
    else return 16'(100 + $urandom % 200);
  endfunction

  // output monitor: decide ready, then score the transfer at the coming edge
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall)
        check(smp_valid && (smp_data == prev_smp), "R8", "stalled sample changed",
              int'(smp_data), int'(prev_smp));
      smp_ready = heavy ? ($urandom % 4 == 0) : ($urandom % 4 != 0);
      if (smp_valid && smp_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected sample", int'(smp_data), -1);
        end else begin
          logic [3:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(smp_data == e, t, "sample value", int'(smp_data), int'(e));
        end
      end
      prev_stall = smp_valid && !smp_ready;
      prev_smp   = smp_data;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] ts;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(smp_valid == 1'b0, "R1", "smp_valid in reset", int'(smp_valid), 0);
    check(byte_ready == 1'b1, "R1", "byte_ready in reset", int'(byte_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    check(smp_valid == 1'b0, "R1", "smp_valid after reset", int'(smp_valid), 0);

    // directed: known bit patterns, byte order, gap rules
    send_cluster(16'h1234, {16'hA5C3, 16'h1248, 16'h8421, 16'h000F,
                            16'h00F0, 16'h0F00, 16'hF000}, 1'b1, "R5", "R3");
    send_cluster(16'h123C, {16'h0102, 16'h0304, 16'h0506, 16'h0708,
                            16'h090A, 16'h0B0C, 16'h0D0E}, 1'b0, "R9", "R2");
    send_cluster(16'h1243, rand_events(), 1'b0, "R4", "R3");
    send_cluster(16'h1243, rand_events(), 1'b0, "R6", "R3");
    // wrap past 0xFFFF: gap 12
    send_cluster(16'hFFF8, rand_events(), 1'b1, "R5", "R3");
    send_cluster(16'h0004, rand_events(), 1'b0, "R6", "R3");
    // partial cluster dropped by block start
    for (int i = 0; i < 5; i++) send_byte(8'($urandom), 1'b0);
    send_cluster(16'h0500, rand_events(), 1'b1, "R5", "R3");
    send_cluster(16'h0520, rand_events(), 1'b0, "R4", "R3");

    // random block longer than a 64-cluster chunk
    ts = 16'($urandom);
    send_cluster(ts, rand_events(), 1'b1, "R5", "R3");
    for (int i = 0; i < 80; i++) begin
      ts = ts + rand_gap();
      send_cluster(ts, rand_events(), 1'b0, "R7", "R3");
    end

    // heavy backpressure phase
    heavy = 1'b1;
    for (int i = 0; i < 20; i++) begin
      ts = ts + rand_gap();
      send_cluster(ts, rand_events(), 1'b0, "R8", "R8");
    end

    begin
      int w;
      w = 0;
      while (exp_q.size() != 0 && w < 40000) begin @(negedge clk); w++; end
    end
    check(exp_q.size() == 0, "R9", "samples still owed", exp_q.size(), 0);
    repeat (20) @(negedge clk);
    check(smp_valid == 1'b0, "R9", "extra sample after drain", int'(smp_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule